// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Watermark DMA Requests

This block holds the sample buffers that sit between a system bus and the serial engine of a PCM audio port. Software or a DMA engine feeds 16-bit playback samples into a transmit FIFO through a register write, and the serial engine drains them with a pop strobe. Going the other way, the serial engine pushes captured samples into a receive FIFO and the bus side drains them by reading a data register. Each read of that register reports in bit 16 whether it really returned a sample. The serial shifter, the bit and frame clock generation and any real bus protocol lie outside the block. A plain single-cycle register strobe interface is used.

Each direction has its own FIFO enable, its own DMA enable and a 6-bit watermark. A DMA request is raised from the fill level: the transmit side asks for more data while it runs low, and the receive side asks to be drained once enough samples have gathered. Six event sources per direction are recorded in sticky status bits: empty, almost empty, full, almost full, starve and overflow. Software clears them by writing ones. A per-source enable and a global enable combine them into one pending bit and an interrupt line. When a FIFO enable is cleared, that FIFO is flushed at once.

Top module: `audio_sample_fifo_pair`

## Requirements
- R1: After reset the control, interrupt-enable and interrupt-status words read 0, both DMA requests and `irq` are low, and the level word (address 5) reads 0x300C.
- R2: Writing address 1 while the transmit FIFO is enabled (control bit 2) queues bits 15:0. `tx_sample` shows the oldest queued sample, and `tx_pop` removes it, so samples leave in write order. The queue holds 32 entries.
- R3: While the receive FIFO is enabled (control bit 1), `rx_push` queues `rx_sample`. Reading address 2 returns the oldest sample in bits 15:0 with bit 16 set and removes it. On an empty FIFO the read returns 0 with bit 16 clear.
- R4: `tx_dreq` is high exactly when the transmit DMA enable (control bit 6) and the transmit FIFO enable are set and the transmit count is at or below the transmit watermark, held in control bits 18:13.
- R5: `rx_dreq` is high exactly when the receive DMA enable (control bit 5) and the receive FIFO enable are set and the receive count is at or above the receive watermark, held in control bits 12:7. The control word reads back as written in these fields.
- R6: The level word carries the transmit count in bits 19:14 and its empty, almost-empty, full and almost-full flags in bits 13, 12, 11 and 10. It carries the receive count in bits 9:4 with the same four flags in bits 3, 2, 1 and 0. Almost empty means a count of 4 or less, and almost full means a count of 28 or more.
- R7: A data write into a full transmit FIFO, or a push into a full receive FIFO, is dropped. The contents and count do not change, and the overflow status bit is set: bit 6 for transmit, bit 0 for receive.
- R8: A pop of an empty FIFO sets the starve status bit: bit 7 for transmit, bit 1 for receive.
- R9: Clearing a FIFO enable empties that FIFO. While it is disabled, pushes, pops and data writes are ignored and set no status bit.
- R10: Status bits (address 4) are transmit empty 11, almost empty 10, full 9, almost full 8, starve 7 and overflow 6, and receive 5 down to 0 in the same order. Level bits are recorded only while the FIFO is enabled. Each bit stays set until a one is written to it at address 6. When an event occurs in the same cycle as its clear, the bit stays set.
- R11: Interrupt enables (address 3) use the status positions, with a global enable at bit 14. Status bit 13 and `irq` are high exactly when the global enable is set and some enabled status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the receive data address) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address, combinational |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| irq | output | 1 | Interrupt, equal to the pending bit |
| tx_pop | input | 1 | Serial engine takes the transmit head sample |
| tx_sample | output | 16 | Transmit head sample |
| rx_push | input | 1 | Serial engine delivers a received sample |
| rx_sample | input | 16 | Received sample |

## Verification
Two cases can land in the same cycle. The first is an event that sets a status bit while a clear write to that bit is in progress. The bench provokes it by enabling an empty transmit FIFO and then writing all ones to the clear register while the FIFO stays empty. The empty and almost-empty bits must then read back as still set, while a later clear after one sample has been queued must drop the empty bit. The second case is a drop on a full FIFO while the data path otherwise runs normally. The bench fills to exactly 32 entries, writes one more, and checks that the overflow bit is set, that the count stays at 32, and that the drained sequence ends with the 32nd accepted sample.

// File: rtl/asf_pkg.sv
package asf_pkg;

   // event slot order inside one direction's 6-bit group
   localparam int unsigned EV_NUM          = 6;
   localparam int unsigned EV_OVERFLOW     = 0;
   localparam int unsigned EV_STARVE       = 1;
   localparam int unsigned EV_ALMOST_FULL  = 2;
   localparam int unsigned EV_FULL         = 3;
   localparam int unsigned EV_ALMOST_EMPTY = 4;
   localparam int unsigned EV_EMPTY        = 5;

   // control word field positions
   localparam int unsigned CTL_TX_WM_LSB = 13;
   localparam int unsigned CTL_RX_WM_LSB = 7;
   localparam int unsigned CTL_TX_DMA    = 6;
   localparam int unsigned CTL_RX_DMA    = 5;
   localparam int unsigned CTL_TX_EN     = 2;
   localparam int unsigned CTL_RX_EN     = 1;

   // interrupt words
   localparam int unsigned IRQ_GLOBAL_BIT = 14;
   localparam int unsigned IRQ_PEND_BIT   = 13;
   localparam int unsigned TX_EV_LSB      = 6;
   localparam int unsigned RX_EV_LSB      = 0;

   // level word
   localparam int unsigned LVL_TX_FLAG_LSB = 10;
   localparam int unsigned LVL_TX_CNT_LSB  = 14;
   localparam int unsigned LVL_RX_FLAG_LSB = 0;
   localparam int unsigned LVL_RX_CNT_LSB  = 4;

   localparam int unsigned RX_VALID_BIT = 16;

   typedef enum logic [2:0] {
      ADDR_CTRL     = 3'd0,
      ADDR_TX_DATA  = 3'd1,
      ADDR_RX_DATA  = 3'd2,
      ADDR_IRQ_EN   = 3'd3,
      ADDR_IRQ_STAT = 3'd4,
      ADDR_LEVEL    = 3'd5,
      ADDR_IRQ_CLR  = 3'd6
   } reg_addr_e;

   typedef struct packed {
      logic empty;
      logic almost_empty;
      logic full;
      logic almost_full;
   } level_flags_t;

endpackage

// File: rtl/asf_fifo.sv
module asf_fifo #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 32,
   parameter int unsigned CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count,
   output logic              push_ok,
   output logic              pop_ok
);
   localparam int unsigned PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit          IS_POW2 = (DEPTH == (1 << PTR_W));
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   initial begin : p_param_check
      assert (DEPTH >= 2) else $error("asf_fifo: DEPTH must be at least 2");
      assert (DEPTH < (1 << CNT_W)) else $error("asf_fifo: CNT_W too narrow for DEPTH");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              is_empty, is_full;

   assign is_empty = (cnt_q == '0);
   assign is_full  = (cnt_q == CNT_FULL);
   assign pop_ok   = pop && !is_empty;
   assign push_ok  = push && (!is_full || pop_ok);

   generate
      if (IS_POW2) begin : g_wrap_natural
         assign rd_nxt = rd_ptr + 1'b1;
         assign wr_nxt = wr_ptr + 1'b1;
      end else begin : g_wrap_compare
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok && !flush) begin
         mem[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head  = mem[rd_ptr];
   assign count = cnt_q;

   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);

   assert_drop_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && is_full && !pop && !flush) |=> (cnt_q == CNT_FULL));

endmodule

// File: rtl/asf_lane.sv
module asf_lane
   import asf_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned DEPTH    = 32,
   parameter int unsigned CNT_W    = 6,
   parameter int unsigned MARGIN   = 4,
   parameter bit          REQ_LOW  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fifo_en,
   input  logic               dma_en,
   input  logic [CNT_W-1:0]   watermark,
   input  logic               push,
   input  logic [DATA_W-1:0]  push_data,
   input  logic               pop,
   output logic [DATA_W-1:0]  head,
   output logic [CNT_W-1:0]   count,
   output level_flags_t       flags,
   input  logic [EV_NUM-1:0]  ev_clr,
   output logic [EV_NUM-1:0]  ev_stat,
   output logic               dreq
);
   localparam logic [CNT_W-1:0] CNT_AEMPTY = CNT_W'(MARGIN);
   localparam logic [CNT_W-1:0] CNT_AFULL  = CNT_W'(DEPTH - MARGIN);
   localparam logic [CNT_W-1:0] CNT_FULL   = CNT_W'(DEPTH);

   initial begin : p_param_check
      assert (MARGIN < DEPTH / 2) else $error("asf_lane: MARGIN must be below half the depth");
   end

   logic              gated_push, gated_pop, push_ok, pop_ok;
   logic [EV_NUM-1:0] ev_set, ev_q;
   logic              level_ok;

   assign gated_push = push && fifo_en;
   assign gated_pop  = pop && fifo_en;

   asf_fifo #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .CNT_W  (CNT_W)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (!fifo_en),
      .push      (gated_push),
      .push_data (push_data),
      .pop       (gated_pop),
      .head      (head),
      .count     (count),
      .push_ok   (push_ok),
      .pop_ok    (pop_ok)
   );

   assign flags.empty        = (count == '0);
   assign flags.almost_empty = (count <= CNT_AEMPTY);
   assign flags.full         = (count == CNT_FULL);
   assign flags.almost_full  = (count >= CNT_AFULL);

   always_comb begin
      ev_set                  = '0;
      ev_set[EV_EMPTY]        = fifo_en && flags.empty;
      ev_set[EV_ALMOST_EMPTY] = fifo_en && flags.almost_empty;
      ev_set[EV_FULL]         = fifo_en && flags.full;
      ev_set[EV_ALMOST_FULL]  = fifo_en && flags.almost_full;
      ev_set[EV_STARVE]       = gated_pop && !pop_ok;
      ev_set[EV_OVERFLOW]     = gated_push && !push_ok;
   end

   // set has priority over a simultaneous write-one-to-clear
   always_ff @(posedge clk) begin
      if (!rst_n) ev_q <= '0;
      else        ev_q <= (ev_q & ~ev_clr) | ev_set;
   end
   assign ev_stat = ev_q;

   generate
      if (REQ_LOW) begin : g_req_refill
         assign level_ok = (count <= watermark);
      end else begin : g_req_drain
         assign level_ok = (count >= watermark);
      end
   endgenerate

   assign dreq = dma_en && fifo_en && level_ok;

   assert_flush_on_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> (count == '0));

   assert_starve_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && pop && (count == '0)) |=> ev_q[EV_STARVE]);

   assert_overflow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_en && push && (count == CNT_FULL) && !pop) |=> ev_q[EV_OVERFLOW]);

   assert_sticky_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_clr == '0) |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

   assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && (ev_clr == '1)) |=> (ev_q == '0));

endmodule

// File: rtl/audio_sample_fifo_pair.sv
module audio_sample_fifo_pair
   import asf_pkg::*;
#(
   parameter int unsigned SAMPLE_W   = 16,
   parameter int unsigned FIFO_DEPTH = 32,
   parameter int unsigned LEVEL_W    = 6,
   parameter int unsigned MARGIN     = 4,
   parameter int unsigned REG_DW     = 32,
   parameter int unsigned REG_AW     = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [REG_DW-1:0]   reg_wdata,
   output logic [REG_DW-1:0]   reg_rdata,
   output logic                tx_dreq,
   output logic                rx_dreq,
   output logic                irq,
   input  logic                tx_pop,
   output logic [SAMPLE_W-1:0] tx_sample,
   input  logic                rx_push,
   input  logic [SAMPLE_W-1:0] rx_sample
);
   localparam int unsigned EV_ALL = 2 * EV_NUM;

   initial begin : p_param_check
      assert (SAMPLE_W <= RX_VALID_BIT) else $error("sample width collides with the valid flag");
      assert (LEVEL_W == 6) else $error("register fields assume 6-bit levels");
      assert (REG_DW >= 20) else $error("register width too small for the level word");
      assert (REG_AW >= 3) else $error("register address too narrow");
   end

   // ---------------- register decode ----------------
   reg_addr_e addr_sel;
   logic      wr_ctrl, wr_txd, wr_ien, wr_clr, rd_rxd;

   assign addr_sel = reg_addr_e'(reg_addr[2:0]);
   assign wr_ctrl  = reg_wr && (reg_addr[REG_AW-1:3] == '0) && (addr_sel == ADDR_CTRL);
   assign wr_txd   = reg_wr && (reg_addr[REG_AW-1:3] == '0) && (addr_sel == ADDR_TX_DATA);
   assign wr_ien   = reg_wr && (reg_addr[REG_AW-1:3] == '0) && (addr_sel == ADDR_IRQ_EN);
   assign wr_clr   = reg_wr && (reg_addr[REG_AW-1:3] == '0) && (addr_sel == ADDR_IRQ_CLR);
   assign rd_rxd   = reg_rd && (reg_addr[REG_AW-1:3] == '0) && (addr_sel == ADDR_RX_DATA);

   // ---------------- control and enables ----------------
   logic [LEVEL_W-1:0] tx_wm_q, rx_wm_q;
   logic               tx_dma_q, rx_dma_q, tx_en_q, rx_en_q;
   logic               ien_glb_q;
   logic [EV_ALL-1:0]  ien_ev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_wm_q   <= '0;
         rx_wm_q   <= '0;
         tx_dma_q  <= 1'b0;
         rx_dma_q  <= 1'b0;
         tx_en_q   <= 1'b0;
         rx_en_q   <= 1'b0;
         ien_glb_q <= 1'b0;
         ien_ev_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            tx_wm_q  <= reg_wdata[CTL_TX_WM_LSB +: LEVEL_W];
            rx_wm_q  <= reg_wdata[CTL_RX_WM_LSB +: LEVEL_W];
            tx_dma_q <= reg_wdata[CTL_TX_DMA];
            rx_dma_q <= reg_wdata[CTL_RX_DMA];
            tx_en_q  <= reg_wdata[CTL_TX_EN];
            rx_en_q  <= reg_wdata[CTL_RX_EN];
         end
         if (wr_ien) begin
            ien_glb_q <= reg_wdata[IRQ_GLOBAL_BIT];
            ien_ev_q  <= reg_wdata[EV_ALL-1:0];
         end
      end
   end

   // ---------------- direction lanes ----------------
   logic [EV_NUM-1:0]   tx_clr, rx_clr, tx_ev, rx_ev;
   logic [LEVEL_W-1:0]  tx_cnt, rx_cnt;
   level_flags_t        tx_flg, rx_flg;
   logic [SAMPLE_W-1:0] rx_head;

   assign tx_clr = wr_clr ? reg_wdata[TX_EV_LSB +: EV_NUM] : '0;
   assign rx_clr = wr_clr ? reg_wdata[RX_EV_LSB +: EV_NUM] : '0;

   asf_lane #(
      .DATA_W  (SAMPLE_W),
      .DEPTH   (FIFO_DEPTH),
      .CNT_W   (LEVEL_W),
      .MARGIN  (MARGIN),
      .REQ_LOW (1'b1)
   ) u_tx_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_en   (tx_en_q),
      .dma_en    (tx_dma_q),
      .watermark (tx_wm_q),
      .push      (wr_txd),
      .push_data (reg_wdata[SAMPLE_W-1:0]),
      .pop       (tx_pop),
      .head      (tx_sample),
      .count     (tx_cnt),
      .flags     (tx_flg),
      .ev_clr    (tx_clr),
      .ev_stat   (tx_ev),
      .dreq      (tx_dreq)
   );

   asf_lane #(
      .DATA_W  (SAMPLE_W),
      .DEPTH   (FIFO_DEPTH),
      .CNT_W   (LEVEL_W),
      .MARGIN  (MARGIN),
      .REQ_LOW (1'b0)
   ) u_rx_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_en   (rx_en_q),
      .dma_en    (rx_dma_q),
      .watermark (rx_wm_q),
      .push      (rx_push),
      .push_data (rx_sample),
      .pop       (rd_rxd),
      .head      (rx_head),
      .count     (rx_cnt),
      .flags     (rx_flg),
      .ev_clr    (rx_clr),
      .ev_stat   (rx_ev),
      .dreq      (rx_dreq)
   );

   // ---------------- interrupt summary ----------------
   logic [EV_ALL-1:0] ev_all;
   logic              pending;

   assign ev_all  = {tx_ev, rx_ev};
   assign pending = ien_glb_q && |(ev_all & ien_ev_q);
   assign irq     = pending;

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      if (reg_addr[REG_AW-1:3] == '0) begin
         case (addr_sel)
            ADDR_CTRL: begin
               reg_rdata[CTL_TX_WM_LSB +: LEVEL_W] = tx_wm_q;
               reg_rdata[CTL_RX_WM_LSB +: LEVEL_W] = rx_wm_q;
               reg_rdata[CTL_TX_DMA]               = tx_dma_q;
               reg_rdata[CTL_RX_DMA]               = rx_dma_q;
               reg_rdata[CTL_TX_EN]                = tx_en_q;
               reg_rdata[CTL_RX_EN]                = rx_en_q;
            end
            ADDR_RX_DATA: begin
               reg_rdata[RX_VALID_BIT] = !rx_flg.empty;
               if (!rx_flg.empty) reg_rdata[SAMPLE_W-1:0] = rx_head;
            end
            ADDR_IRQ_EN: begin
               reg_rdata[IRQ_GLOBAL_BIT] = ien_glb_q;
               reg_rdata[EV_ALL-1:0]     = ien_ev_q;
            end
            ADDR_IRQ_STAT: begin
               reg_rdata[IRQ_PEND_BIT] = pending;
               reg_rdata[EV_ALL-1:0]   = ev_all;
            end
            ADDR_LEVEL: begin
               reg_rdata[LVL_TX_CNT_LSB +: LEVEL_W] = tx_cnt;
               reg_rdata[LVL_TX_FLAG_LSB +: 4]      = tx_flg;
               reg_rdata[LVL_RX_CNT_LSB +: LEVEL_W] = rx_cnt;
               reg_rdata[LVL_RX_FLAG_LSB +: 4]      = rx_flg;
            end
            default: reg_rdata = '0;
         endcase
      end
   end

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^reg_wdata;

   assert_irq_needs_global_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ien && !reg_wdata[IRQ_GLOBAL_BIT]) |=> !irq);

   assert_rx_read_pops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rxd && rx_en_q && !rx_push && (rx_cnt != '0)) |=> (rx_cnt == $past(rx_cnt) - 1'b1));

endmodule

// File: tb/audio_sample_fifo_pair_test.sv
module audio_sample_fifo_pair_test;
   localparam logic [2:0] A_CTRL = 3'd0, A_TXD = 3'd1, A_RXD = 3'd2, A_IEN = 3'd3,
                          A_STAT = 3'd4, A_LVL = 3'd5, A_CLR = 3'd6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tx_dreq, rx_dreq, irq;
   logic        tx_pop = 1'b0, rx_push = 1'b0;
   logic [15:0] tx_sample;
   logic [15:0] rx_sample = '0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   audio_sample_fifo_pair uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .tx_dreq   (tx_dreq),
      .rx_dreq   (rx_dreq),
      .irq       (irq),
      .tx_pop    (tx_pop),
      .tx_sample (tx_sample),
      .rx_push   (rx_push),
      .rx_sample (rx_sample)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic serial_pop(output logic [15:0] s);
      @(negedge clk);
      s = tx_sample; tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
   endtask

   task automatic serial_push(input logic [15:0] s);
      @(negedge clk);
      rx_sample = s; rx_push = 1'b1;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic cleanup();
      wr(A_CTRL, 32'h0);
      wr(A_CLR, 32'h3FFF);
   endtask

   task automatic test_reset();
      logic [31:0] v;
      @(negedge clk);
      check("R1 dreq/irq", {29'd0, tx_dreq, rx_dreq, irq}, 32'h0);
      rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
      rd(A_IEN, v);  check("R1 ien", v, 32'h0);
      rd(A_STAT, v); check("R1 stat", v, 32'h0);
      rd(A_LVL, v);  check("R1 level", v, 32'h300C);
   endtask

   task automatic test_tx_order();
      logic [31:0] v;
      logic [15:0] s;
      wr(A_CTRL, 32'h4);
      wr(A_TXD, 32'hA1A1); wr(A_TXD, 32'hB2B2); wr(A_TXD, 32'hC3C3);
      rd(A_LVL, v); check("R2 level 3", v, 32'hD00C);
      serial_pop(s); check("R2 pop 0", {16'd0, s}, 32'hA1A1);
      serial_pop(s); check("R2 pop 1", {16'd0, s}, 32'hB2B2);
      serial_pop(s); check("R2 pop 2", {16'd0, s}, 32'hC3C3);
      rd(A_LVL, v); check("R2 drained", v, 32'h300C);
      cleanup();
   endtask

   task automatic test_rx_read();
      logic [31:0] v;
      wr(A_CTRL, 32'h2);
      serial_push(16'h1234); serial_push(16'hBEEF);
      rd(A_RXD, v); check("R3 read 0", v, 32'h0001_1234);
      rd(A_RXD, v); check("R3 read 1", v, 32'h0001_BEEF);
      rd(A_RXD, v); check("R3 read empty", v, 32'h0);
      rd(A_STAT, v); check("R8 rx starve", v & 32'h2, 32'h2);
      cleanup();
   endtask

   task automatic test_watermarks();
      logic [31:0] v;
      logic [15:0] s;
      wr(A_CTRL, 32'h4044);
      check("R4 empty req", {31'd0, tx_dreq}, 32'h1);
      wr(A_TXD, 32'h1); wr(A_TXD, 32'h2);
      @(negedge clk); check("R4 at wm", {31'd0, tx_dreq}, 32'h1);
      wr(A_TXD, 32'h3);
      @(negedge clk); check("R4 above wm", {31'd0, tx_dreq}, 32'h0);
      serial_pop(s);
      check("R4 back at wm", {31'd0, tx_dreq}, 32'h1);
      wr(A_CTRL, 32'h4004);
      check("R4 dma off", {31'd0, tx_dreq}, 32'h0);
      cleanup();
      wr(A_CTRL, 32'h1A2);
      rd(A_CTRL, v); check("R5 ctrl readback", v, 32'h1A2);
      serial_push(16'h10); serial_push(16'h11);
      check("R5 below wm", {31'd0, rx_dreq}, 32'h0);
      serial_push(16'h12);
      check("R5 at wm", {31'd0, rx_dreq}, 32'h1);
      rd(A_RXD, v);
      check("R5 after read", {31'd0, rx_dreq}, 32'h0);
      cleanup();
   endtask

   task automatic test_levels_overflow();
      logic [31:0] v;
      logic [15:0] s;
      wr(A_CTRL, 32'h4);
      for (int i = 0; i < 28; i++) wr(A_TXD, 32'h100 + i);
      rd(A_LVL, v); check("R6 almost full", v, 32'h7040C);
      for (int i = 28; i < 32; i++) wr(A_TXD, 32'h100 + i);
      rd(A_LVL, v); check("R6 full", v, 32'h80C0C);
      rd(A_STAT, v); check("R7 no overflow yet", v & 32'h40, 32'h0);
      wr(A_TXD, 32'hDEAD);
      rd(A_STAT, v); check("R7 tx overflow", v & 32'h40, 32'h40);
      rd(A_LVL, v); check("R7 count held", v, 32'h80C0C);
      for (int i = 0; i < 32; i++) begin
         serial_pop(s);
         check("R7 drain order", {16'd0, s}, 32'h100 + i);
      end
      cleanup();
      wr(A_CTRL, 32'h2);
      for (int i = 0; i < 33; i++) serial_push(16'h200 + i[15:0]);
      rd(A_STAT, v); check("R7 rx overflow", v & 32'h1, 32'h1);
      rd(A_LVL, v); check("R6 rx full", v, 32'h3203);
      rd(A_RXD, v); check("R7 rx head", v, 32'h0001_0200);
      cleanup();
   endtask

   task automatic test_starve();
      logic [31:0] v;
      logic [15:0] s;
      wr(A_CTRL, 32'h4);
      rd(A_STAT, v); check("R8 before pop", v & 32'h80, 32'h0);
      serial_pop(s);
      rd(A_STAT, v); check("R8 tx starve", v & 32'h80, 32'h80);
      cleanup();
   endtask

   task automatic test_flush();
      logic [31:0] v;
      logic [15:0] s;
      wr(A_CTRL, 32'h6);
      for (int i = 0; i < 5; i++) wr(A_TXD, 32'h40 + i);
      for (int i = 0; i < 3; i++) serial_push(16'h50 + i[15:0]);
      wr(A_CTRL, 32'h0);
      rd(A_LVL, v); check("R9 flushed", v, 32'h300C);
      wr(A_CLR, 32'h3FFF);
      serial_pop(s);
      serial_push(16'h7777);
      wr(A_TXD, 32'h5555);
      rd(A_STAT, v); check("R9 no events while off", v, 32'h0);
      rd(A_LVL, v); check("R9 nothing queued", v, 32'h300C);
      wr(A_CTRL, 32'h6);
      rd(A_RXD, v); check("R9 rx stays empty", v, 32'h0);
      cleanup();
   endtask

   task automatic test_clear_collision();
      logic [31:0] v;
      wr(A_CTRL, 32'h4);
      wr(A_CLR, 32'h3FFF);
      rd(A_STAT, v); check("R10 set beats clear", v, 32'hC00);
      wr(A_TXD, 32'h99);
      rd(A_STAT, v); check("R10 sticky empty", v, 32'hC00);
      wr(A_CLR, 32'h3FFF);
      rd(A_STAT, v); check("R10 cleared", v, 32'h400);
   endtask

   task automatic test_irq();
      logic [31:0] v;
      logic [15:0] s;
      wr(A_IEN, 32'h4080);
      rd(A_IEN, v); check("R11 ien readback", v, 32'h4080);
      rd(A_STAT, v); check("R11 not pending", v, 32'h400);
      check("R11 irq low", {31'd0, irq}, 32'h0);
      serial_pop(s);
      serial_pop(s);
      rd(A_STAT, v); check("R11 pending", v, 32'h2C80);
      check("R11 irq high", {31'd0, irq}, 32'h1);
      wr(A_IEN, 32'h0080);
      check("R11 global off", {31'd0, irq}, 32'h0);
      rd(A_STAT, v); check("R11 pend off", v, 32'h0C80);
      wr(A_IEN, 32'h4080);
      check("R11 global on", {31'd0, irq}, 32'h1);
      wr(A_CLR, 32'h80);
      check("R11 cleared irq", {31'd0, irq}, 32'h0);
      rd(A_STAT, v); check("R11 cleared stat", v & 32'h2080, 32'h0);
      cleanup();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_tx_order();
      test_rx_read();
      test_watermarks();
      test_levels_overflow();
      test_starve();
      test_flush();
      test_clear_collision();
      test_irq();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule